// File: doc/BRIEF.md
# Bus redirect and mirroring controller

This block sits on the CPU side of an enhanced bank controller and handles accesses to the upper half of the CPU address space, from $8000 to $FFFF. A CPU write enters on a valid/ready channel and leaves on a second valid/ready channel, toward the bank controller's command/data port or its scanline-interrupt registers. On the way the block may rewrite the address. In discrete-board emulation modes every write is folded onto the command/data port pair. On the board variant that inverts the counter reload value, writes to the interrupt registers have their data complemented.

On reads, the block can replace CPU address bit 0 with a small pad value held inside the block. That value is cleared at power-on and steps forward on each soft reset, so a cartridge menu can tell successive soft resets apart. The block also produces a registered 2-bit nametable mirroring code. The code comes from one of three sources: a single-screen choice driven by a bank bit, an extended four-way field, or the plain one-bit horizontal/vertical field.

The write channel has no storage. `cpu_wr_ready` follows `out_ready` for writes to $8000 and above, so back-pressure passes straight through to the CPU side. Writes below $8000 are accepted at once and produce nothing on the outgoing channel. An item moves on a channel in a cycle where both valid and ready are high. While stalled, the CPU side must hold its address and data.

Top module: `bus_redirect_mirror`

## Requirements
- R1: When `reg3[0]` and `reg3[3]` are both 1, a write to any address in $8000–$FFFF leaves with address $8001, unchanged data and `out_irq`=0. Bit 3 being set forces A0 to 1. This takes priority over the interrupt-register decode of R3.
- R2: When only one of `reg3[0]` and `reg3[3]` is 1, writes are not redirected, and addresses $8000–$BFFF leave unchanged.
- R3: A non-redirected write to $C000–$FFFF leaves with its address unchanged and `out_irq`=1. Its data is complemented (XOR $FF) when `invert_strap`=1 and unchanged otherwise.
- R4: A non-redirected write to $8000–$BFFF leaves with address and data unchanged and `out_irq`=0.
- R5: A write with address bit 15 = 0 is accepted (`cpu_wr_ready`=1) and produces no outgoing item (`out_valid`=0).
- R6: For a write to $8000–$FFFF, `out_valid` equals `cpu_wr_valid` and `cpu_wr_ready` equals `out_ready`, in the same cycle.
- R7: While `cpu_rd`=1, `reg1[0]`=1 and address bit 15 = 1, `rd_addr` is `cpu_addr` with bit 0 replaced by bit 0 of the pad value. In every other case `rd_addr` equals `cpu_addr`.
- R8: The pad value is 0 after `rst_n` and increases by one on each clock where `soft_rst`=1.
- R9: When `reg3[5]`=1, the mirroring code is single-screen. It is 3 (screen 1) if `bank6[4]`=1 and 2 (screen 0) otherwise.
- R10: When `reg3[5]`=0 and `reg1[1]`=1, the mirroring code equals `mirr_reg[1:0]`. The codes are 0 vertical, 1 horizontal, 2 screen 0 and 3 screen 1.
- R11: When `reg3[5]`=0 and `reg1[1]`=0, the mirroring code is 1 (horizontal) if `mirr_reg[0]`=1 and 0 (vertical) otherwise.
- R12: `mirror` is 0 after reset. It takes the value selected by R9–R11 on the clock edge where `cfg_upd`=1, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| soft_rst | input | 1 | Soft reset pulse; steps the pad value |
| invert_strap | input | 1 | Board variant: complement interrupt-register write data |
| reg1 | input | 8 | Mode register 1 (bit 0 pad substitution, bit 1 extended mirroring) |
| reg3 | input | 8 | Mode register 3 (bits 0 and 3 redirect, bit 5 single-screen) |
| bank6 | input | 8 | Bank register 6 (bit 4 picks the single screen) |
| mirr_reg | input | 8 | Mirroring register written by the CPU |
| cfg_upd | input | 1 | Pulse after any register write; reloads mirroring |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr_valid | input | 1 | CPU write valid |
| cpu_wr_ready | output | 1 | CPU write ready |
| out_valid | output | 1 | Outgoing write valid |
| out_ready | input | 1 | Outgoing write ready |
| out_addr | output | 16 | Outgoing write address |
| out_data | output | 8 | Outgoing write data |
| out_irq | output | 1 | Outgoing write targets the interrupt registers |
| cpu_rd | input | 1 | CPU read strobe |
| rd_addr | output | 16 | Read address after pad substitution |
| mirror | output | 2 | Registered mirroring code |

## Verification
On every cycle, the assertions check the handshake coupling and the dropping of low-address writes. They also check that redirected writes always land on $8001, that the interrupt data is complemented on the inverting variant, that the pad steps by one on a soft reset, and that the mirroring code holds between update pulses. Other behaviours only show up in the bench's scenarios. These include the three-way mirroring priority with its exact codes, redirection outranking the interrupt decode, the pad value as seen through a read over a series of soft resets, and a stall while `out_ready` is low.

// File: rtl/brm_pkg.sv
package brm_pkg;

  // Nametable mirroring codes driven on the mirror output.
  typedef enum logic [1:0] {
    MIR_VERT = 2'd0,
    MIR_HORZ = 2'd1,
    MIR_SCR0 = 2'd2,
    MIR_SCR1 = 2'd3
  } mirr_t;

  // Bit positions inside the mode registers that this block decodes.
  localparam int R3_NROM_BIT   = 0;
  localparam int R3_DISC_BIT   = 3;
  localparam int R3_SINGLE_BIT = 5;
  localparam int R1_PAD_BIT    = 0;
  localparam int R1_EXTMIR_BIT = 1;
  localparam int B6_SCREEN_BIT = 4;

endpackage

// File: rtl/brm_pad_ctr.sv
module brm_pad_ctr #(
  parameter int PAD_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  output logic [PAD_W-1:0] pad_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pad_q <= '0;
    else if (soft_rst) pad_q <= pad_q + PAD_W'(1);
  end

  // R8
  pad_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> pad_q == $past(pad_q) + PAD_W'(1));

endmodule

// File: rtl/brm_wr_route.sv
module brm_wr_route #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              invert_strap,
  input  logic              mode_nrom,
  input  logic              mode_disc,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic              out_irq
);

  localparam logic [ADDR_W-1:0] PORT_BASE = {1'b1, {(ADDR_W-1){1'b0}}};
  localparam int HI_BIT  = ADDR_W - 1;
  localparam int IRQ_BIT = ADDR_W - 2;

  logic in_hi;
  logic redir;
  logic redir_a0;

  assign in_hi    = in_addr[HI_BIT];
  assign redir    = mode_nrom & mode_disc;
  assign redir_a0 = mode_disc ? 1'b1 : in_addr[0];

  assign out_valid = in_valid & in_hi;
  assign in_ready  = in_hi ? out_ready : 1'b1;

  always_comb begin
    out_addr = in_addr;
    out_data = in_data;
    out_irq  = 1'b0;
    if (redir) begin
      out_addr = PORT_BASE | ADDR_W'(redir_a0);
    end else if (in_addr[IRQ_BIT]) begin
      out_irq  = 1'b1;
      out_data = in_data ^ {DATA_W{invert_strap}};
    end
  end

  // R5
  low_addr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_addr[HI_BIT]) |-> (!out_valid && in_ready));

  // R1
  redirect_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mode_nrom && mode_disc) |-> (out_addr == (PORT_BASE | ADDR_W'(1)) && !out_irq));

  // R3
  irq_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_irq && invert_strap) |-> (out_data == ~in_data));

  // R6
  backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: rtl/brm_mirror_sel.sv
module brm_mirror_sel
  import brm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd,
  input  logic       single_en,
  input  logic       single_pick,
  input  logic       ext_en,
  input  logic [1:0] mreg,
  output mirr_t      mirror_q
);

  mirr_t mirror_d;

  always_comb begin
    if (single_en)   mirror_d = single_pick ? MIR_SCR1 : MIR_SCR0;
    else if (ext_en) mirror_d = mirr_t'(mreg);
    else             mirror_d = mreg[0] ? MIR_HORZ : MIR_VERT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   mirror_q <= MIR_VERT;
    else if (upd) mirror_q <= mirror_d;
  end

  // R12
  mirror_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(mirror_q));

  // R9
  single_screen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && single_en) |=> mirror_q[1]);

  // R11
  basic_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !single_en && !ext_en) |=> !mirror_q[1]);

endmodule

// File: rtl/bus_redirect_mirror.sv
module bus_redirect_mirror
  import brm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int REG_W  = 8,
  parameter int PAD_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              invert_strap,
  input  logic [REG_W-1:0]  reg1,
  input  logic [REG_W-1:0]  reg3,
  input  logic [REG_W-1:0]  bank6,
  input  logic [REG_W-1:0]  mirr_reg,
  input  logic              cfg_upd,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_wr_valid,
  output logic              cpu_wr_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic              out_irq,
  input  logic              cpu_rd,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        mirror
);

  logic [PAD_W-1:0] pad_q;
  logic             pad_sub;
  mirr_t            mirror_q;
  logic             unused_bits;

  assign unused_bits = ^{reg1, reg3, bank6, mirr_reg, pad_q};

  brm_pad_ctr #(.PAD_W(PAD_W)) u_pad (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .pad_q    (pad_q)
  );

  brm_wr_route #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk          (clk),
    .rst_n        (rst_n),
    .invert_strap (invert_strap),
    .mode_nrom    (reg3[R3_NROM_BIT]),
    .mode_disc    (reg3[R3_DISC_BIT]),
    .in_addr      (cpu_addr),
    .in_data      (cpu_wdata),
    .in_valid     (cpu_wr_valid),
    .in_ready     (cpu_wr_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_addr     (out_addr),
    .out_data     (out_data),
    .out_irq      (out_irq)
  );

  brm_mirror_sel u_mir (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd         (cfg_upd),
    .single_en   (reg3[R3_SINGLE_BIT]),
    .single_pick (bank6[B6_SCREEN_BIT]),
    .ext_en      (reg1[R1_EXTMIR_BIT]),
    .mreg        (mirr_reg[1:0]),
    .mirror_q    (mirror_q)
  );

  assign mirror = mirror_q;

  // Read path: A0 substitution with the pad value.
  assign pad_sub = cpu_rd & reg1[R1_PAD_BIT] & cpu_addr[ADDR_W-1];
  assign rd_addr = pad_sub ? {cpu_addr[ADDR_W-1:1], pad_q[0]} : cpu_addr;

  // R7
  rd_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd |-> rd_addr == cpu_addr);

  // R7
  rd_upper_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr[ADDR_W-1:1] == cpu_addr[ADDR_W-1:1]);

endmodule

// File: tb/test_bus_redirect_mirror.sv
module test_bus_redirect_mirror;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        invert_strap = 1'b0;
  logic [7:0]  reg1 = '0, reg3 = '0, bank6 = '0, mirr_reg = '0;
  logic        cfg_upd = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr_valid = 1'b0;
  logic        cpu_wr_ready;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_addr;
  logic [7:0]  out_data;
  logic        out_irq;
  logic        cpu_rd = 1'b0;
  logic [15:0] rd_addr;
  logic [1:0]  mirror;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] a;
    logic [7:0]  d;
    logic        irq;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  bus_redirect_mirror i_bus_redirect_mirror (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .invert_strap(invert_strap),
    .reg1(reg1), .reg3(reg3), .bank6(bank6), .mirr_reg(mirr_reg), .cfg_upd(cfg_upd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr_valid(cpu_wr_valid),
    .cpu_wr_ready(cpu_wr_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_data(out_data), .out_irq(out_irq),
    .cpu_rd(cpu_rd), .rd_addr(rd_addr), .mirror(mirror)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every accepted outgoing item.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (sb.size() == 0) begin
        vectors++; fails++;
        $display("FAIL R5: actual item %0h expected none", out_addr);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " addr"}, 32'(out_addr), 32'(e.a));
        check({e.tag, " data"}, 32'(out_data), 32'(e.d));
        check({e.tag, " irq"},  32'(out_irq),  32'(e.irq));
      end
    end
  end

  // Driver: one write per cycle; pushes the expected item if one should leave.
  task automatic wr(input logic [15:0] a, input logic [7:0] d, input bit emit,
                    input logic [15:0] ea, input logic [7:0] ed, input logic eirq,
                    input string tag);
    @(posedge clk); #1;
    cpu_addr = a; cpu_wdata = d; cpu_wr_valid = 1'b1;
    if (emit) sb.push_back('{ea, ed, eirq, tag});
    @(negedge clk);
    check("R6 ready", 32'(cpu_wr_ready), emit ? 32'(out_ready) : 32'd1);
    @(posedge clk); #1;
    cpu_wr_valid = 1'b0;
  endtask

  task automatic upd_mirror(input logic [1:0] exp, input string tag);
    @(posedge clk); #1 cfg_upd = 1'b1;
    @(posedge clk); #1 cfg_upd = 1'b0;
    check(tag, 32'(mirror), 32'(exp));
  endtask

  task automatic soft_pulse();
    @(posedge clk); #1 soft_rst = 1'b1;
    @(posedge clk); #1 soft_rst = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      vectors++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 reset mirror", 32'(mirror), 32'd0);
    check("R6 idle out_valid", 32'(out_valid), 32'd0);

    // R1 redirect, priority over IRQ decode
    reg3 = 8'h09; invert_strap = 1'b1;
    wr(16'hA000, 8'h3C, 1, 16'h8001, 8'h3C, 1'b0, "R1 redirect A000");
    wr(16'hE002, 8'h55, 1, 16'h8001, 8'h55, 1'b0, "R1 redirect E002");
    // R2 only one bit
    reg3 = 8'h01; invert_strap = 1'b0;
    wr(16'hC000, 8'h12, 1, 16'hC000, 8'h12, 1'b1, "R2 bit0 only C000");
    reg3 = 8'h08;
    wr(16'h9000, 8'h77, 1, 16'h9000, 8'h77, 1'b0, "R2 bit3 only 9000");
    // R3 inverted IRQ data
    reg3 = 8'h00; invert_strap = 1'b1;
    wr(16'hC001, 8'h0F, 1, 16'hC001, 8'hF0, 1'b1, "R3 invert C001");
    invert_strap = 1'b0;
    wr(16'hFFFF, 8'hA5, 1, 16'hFFFF, 8'hA5, 1'b1, "R3 plain FFFF");
    // R4 pass
    wr(16'h8000, 8'h06, 1, 16'h8000, 8'h06, 1'b0, "R4 pass 8000");
    wr(16'hBFFF, 8'h81, 1, 16'hBFFF, 8'h81, 1'b0, "R4 pass BFFF");
    // R5 low write dropped
    wr(16'h6002, 8'h99, 0, 16'h0, 8'h0, 1'b0, "R5 drop");
    // R6 back-pressure
    @(posedge clk); #1;
    out_ready = 1'b0; cpu_addr = 16'h8001; cpu_wdata = 8'h11; cpu_wr_valid = 1'b1;
    @(negedge clk);
    check("R6 stall ready", 32'(cpu_wr_ready), 32'd0);
    check("R6 stall valid", 32'(out_valid), 32'd1);
    @(posedge clk); #1 cpu_wr_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    check("R6 released valid", 32'(out_valid), 32'd0);

    // R7/R8 pad substitution
    cpu_rd = 1'b1; reg1 = 8'h01; cpu_addr = 16'h8123; #1;
    check("R8 pad after power-on", 32'(rd_addr), 32'h8122);
    soft_pulse(); #1;
    check("R8 pad after 1 soft reset", 32'(rd_addr), 32'h8123);
    cpu_addr = 16'hC456; #1;
    check("R7 substitute C456", 32'(rd_addr), 32'hC457);
    cpu_addr = 16'h4456; #1;
    check("R7 low read untouched", 32'(rd_addr), 32'h4456);
    reg1 = 8'h00; cpu_addr = 16'hC456; #1;
    check("R7 disabled", 32'(rd_addr), 32'hC456);
    reg1 = 8'h01; cpu_rd = 1'b0; #1;
    check("R7 no strobe", 32'(rd_addr), 32'hC456);
    cpu_rd = 1'b1;
    soft_pulse(); #1;
    check("R8 pad after 2 soft resets", 32'(rd_addr), 32'hC456);
    cpu_rd = 1'b0;

    // Mirroring
    reg1 = 8'h02; reg3 = 8'h20; bank6 = 8'h10; mirr_reg = 8'h01;
    upd_mirror(2'd3, "R9 screen1 over extended");
    bank6 = 8'h00;
    upd_mirror(2'd2, "R9 screen0");
    reg3 = 8'h00; mirr_reg = 8'h02;
    upd_mirror(2'd2, "R10 ext code 2");
    mirr_reg = 8'h01;
    upd_mirror(2'd1, "R10 ext code 1");
    mirr_reg = 8'h03;
    upd_mirror(2'd3, "R10 ext code 3");
    reg1 = 8'h00;
    upd_mirror(2'd1, "R11 basic horizontal");
    mirr_reg = 8'h02;
    upd_mirror(2'd0, "R11 basic vertical");
    mirr_reg = 8'h01; reg3 = 8'h20;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R12 hold without update", 32'(mirror), 32'd0);

    repeat (2) @(posedge clk);
    check("scoreboard drained", 32'(sb.size()), 32'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule